// File: doc/BRIEF.md
# Dual-Neighbour Memory Tile with Instruction Streaming

This block is a word-addressed storage tile placed between two neighbouring processors. In data mode, either neighbour can issue single-word reads and writes. A small round-robin arbiter resolves collisions, so only one access reaches the storage array in any cycle. Each granted access gets a response one cycle after its grant.

In instruction mode, the tile drives program sequencing for a processor. It keeps its own 16-bit program counter and assembles each 40-bit instruction from three consecutive storage words. It presents the instructions one at a time on a valid/ready stream. A branch input reloads the counter and throws away any instruction already fetched but not yet taken.

The full-size tile holds 32,768 sixteen-bit words, which gives room for 10,922 instructions. The storage depth is a parameter, and the instruction limit is derived from it as depth divided by three. The default build uses 2,048 words, which gives 682 instructions. A one-bit configuration register selects the mode. That register can only be written while the tile is quiet.

Top module: `mem_tile_stream`

## Requirements
- R1: In data mode, a write stores `req_wdata` at `req_addr`. A read returns the stored word on `rsp_rdata` of the same port, with `rsp_valid` high, in the cycle after the grant. Every grant gives exactly one response on the granted port.
- R2: When both ports request in the same cycle, exactly one is granted. The winner is the port that was not granted most recently, and port 0 wins the first collision after reset. The losing port sees `req_ready` low and is granted in the next cycle if it keeps requesting.
- R3: A request from one port alone, in data mode, is granted in the same cycle (`req_ready` high).
- R4: A data address at or above the storage depth makes the response carry `rsp_err` = 1 and `rsp_rdata` = 0. A write to such an address changes no stored word.
- R5: Instruction k is assembled from word addresses 3k, 3k+1 and 3k+2. Word 3k supplies bits 15:0, word 3k+1 supplies bits 31:16, and bits 7:0 of word 3k+2 supply bits 39:32. Bits 15:8 of word 3k+2 do not affect the instruction.
- R6: In instruction mode, instructions come out in counter order starting at 0. One instruction is taken per cycle in which `ins_valid` and `ins_ready` are both high. While `ins_ready` is low, `ins_valid`, `ins_data` and `ins_err` hold steady.
- R7: In instruction mode, a cycle with `br_valid` high loads `br_target` into the counter and drops `ins_valid` in the next cycle. The next instruction delivered is the one at `br_target`.
- R8: A counter value at or above depth/3 yields an instruction with `ins_err` = 1 and `ins_data` = 0. The counter does not advance past that value.
- R9: `cfg_mode` (0 = data, 1 = instruction) is written through `cfg_we`. The write is ignored in any cycle where a `req_valid` or `br_valid` is high. A write that changes the mode clears the counter to 0.
- R10: In instruction mode, both `req_ready` outputs stay low. In data mode, `ins_valid` stays low and `br_valid` has no effect.
- R11: After reset, the tile is in data mode with no response and no instruction pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 1 | Mode value: 0 data, 1 instruction |
| req_valid | input | 2 | Per-port access request |
| req_ready | output | 2 | Per-port grant |
| req_we | input | 2 | Per-port write select |
| req_addr | input | 2x16 | Per-port word address |
| req_wdata | input | 2x16 | Per-port write data |
| rsp_valid | output | 2 | Per-port response strobe |
| rsp_err | output | 2 | Per-port address error |
| rsp_rdata | output | 2x16 | Per-port read data |
| br_valid | input | 1 | Branch strobe |
| br_target | input | 16 | Branch target instruction index |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Consumer accepts instruction |
| ins_data | output | 40 | Assembled instruction |
| ins_err | output | 1 | Counter out of range |

## Verification
If the arbiter pointer is wrong, the wrong port wins the next collision: `req_ready` shows the wrong winner in that same cycle. If the fetch word index or the packing slices are wrong, the first delivered instruction has scrambled bit fields, which shows on `ins_data` about four cycles after the stream starts. If the counter is not reloaded or the prefetch is not flushed on a branch, `ins_valid` stays high in the cycle after the branch, or a later instruction does not match the branch target. A fault in the range check shows at once as a missing `ins_err` or `rsp_err`, or as non-zero data.

// File: rtl/mtile_pkg.sv
package mtile_pkg;
   typedef enum logic {
      MODE_DATA  = 1'b0,
      MODE_INSTR = 1'b1
   } mtile_mode_e;
endpackage

// File: rtl/mtile_ram.sv
module mtile_ram #(
   parameter int DEPTH  = 2048,
   parameter int DATA_W = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) store[addr] <= wdata;
         else    q <= store[addr];
      end
   end
endmodule

// File: rtl/mtile_arb.sv
module mtile_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   logic last_one;   // 1 when port 1 held the most recent grant

   always_comb begin
      if (!enable)           gnt = 2'b00;
      else if (req == 2'b11) gnt = last_one ? 2'b01 : 2'b10;
      else                   gnt = req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      last_one <= 1'b1;
      else if (|gnt)   last_one <= gnt[1];
   end
endmodule

// File: rtl/mtile_fetch.sv
module mtile_fetch #(
   parameter int PC_W    = 16,
   parameter int AW      = 11,
   parameter int DATA_W  = 16,
   parameter int INSTR_W = 40,
   parameter int WPI     = 3,
   parameter int PC_MAX  = 682,
   localparam int IDX_W  = $clog2(WPI),
   localparam int CAT_W  = WPI * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               restart,
   input  logic               br_valid,
   input  logic [PC_W-1:0]    br_target,
   input  logic               ins_ready,
   input  logic [DATA_W-1:0]  q,
   output logic               rd_en,
   output logic [AW-1:0]      rd_addr,
   output logic               ins_valid,
   output logic [INSTR_W-1:0] ins_data,
   output logic               ins_err
);
   localparam logic [PC_W-1:0]  PC_LIMIT = PC_W'(PC_MAX);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WPI - 1);

   logic [PC_W-1:0]   pc;
   logic [IDX_W-1:0]  issue_idx, ret_idx;
   logic              waiting, ret_vld;
   logic [DATA_W-1:0] words [WPI];
   logic [CAT_W-1:0]  cat;
   logic              pc_bad, can_issue;

   assign pc_bad    = pc >= PC_LIMIT;
   assign can_issue = run && !br_valid && !ins_valid && !waiting;
   assign rd_en     = can_issue && !pc_bad;
   assign rd_addr   = AW'(pc) * AW'(WPI) + AW'(issue_idx);

   for (genvar w = 0; w < WPI; w++) begin : g_pack
      if (w == WPI - 1) begin : g_last
         assign cat[w*DATA_W +: DATA_W] = q;
      end else begin : g_held
         assign cat[w*DATA_W +: DATA_W] = words[w];
      end
   end

   if (CAT_W > INSTR_W) begin : g_tail
      logic unused_tail;
      assign unused_tail = ^cat[CAT_W-1:INSTR_W];
   end

   always_ff @(posedge clk) begin
      if (ret_vld && !br_valid) words[ret_idx] <= q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         pc        <= '0;
         issue_idx <= '0;
         ret_idx   <= '0;
         waiting   <= 1'b0;
         ret_vld   <= 1'b0;
         ins_valid <= 1'b0;
         ins_err   <= 1'b0;
         ins_data  <= '0;
      end else if (run && br_valid) begin
         pc        <= br_target;
         issue_idx <= '0;
         waiting   <= 1'b0;
         ret_vld   <= 1'b0;
         ins_valid <= 1'b0;
         ins_err   <= 1'b0;
      end else begin
         if (ins_valid && ins_ready) ins_valid <= 1'b0;
         ret_vld <= rd_en;
         ret_idx <= issue_idx;
         if (can_issue && pc_bad) begin
            ins_valid <= 1'b1;
            ins_err   <= 1'b1;
            ins_data  <= '0;
         end
         if (rd_en) begin
            if (issue_idx == LAST_IDX) begin
               issue_idx <= '0;
               waiting   <= 1'b1;
            end else begin
               issue_idx <= issue_idx + 1'b1;
            end
         end
         if (ret_vld && ret_idx == LAST_IDX) begin
            waiting   <= 1'b0;
            ins_valid <= 1'b1;
            ins_err   <= 1'b0;
            ins_data  <= cat[INSTR_W-1:0];
            pc        <= pc + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mem_tile_stream.sv
module mem_tile_stream #(
   parameter int DEPTH           = 2048,
   parameter int DATA_W          = 16,
   parameter int ADDR_W          = 16,
   parameter int PC_W            = 16,
   parameter int INSTR_W         = 40,
   parameter int WORDS_PER_INSTR = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic                        cfg_mode,
   input  logic [1:0]                  req_valid,
   output logic [1:0]                  req_ready,
   input  logic [1:0]                  req_we,
   input  logic [1:0][ADDR_W-1:0]      req_addr,
   input  logic [1:0][DATA_W-1:0]      req_wdata,
   output logic [1:0]                  rsp_valid,
   output logic [1:0]                  rsp_err,
   output logic [1:0][DATA_W-1:0]      rsp_rdata,
   input  logic                        br_valid,
   input  logic [PC_W-1:0]             br_target,
   output logic                        ins_valid,
   input  logic                        ins_ready,
   output logic [INSTR_W-1:0]          ins_data,
   output logic                        ins_err
);
   import mtile_pkg::*;

   localparam int AW     = $clog2(DEPTH);
   localparam int PC_MAX = DEPTH / WORDS_PER_INSTR;
   localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

   if (WORDS_PER_INSTR * DATA_W < INSTR_W) begin : g_chk_pack
      $error("instruction does not fit in its words");
   end
   if (WORDS_PER_INSTR < 2) begin : g_chk_wpi
      $error("an instruction must span at least two words");
   end
   if (DEPTH > (1 << ADDR_W)) begin : g_chk_addr
      $error("address port narrower than storage");
   end
   if (PC_MAX >= (1 << PC_W)) begin : g_chk_pc
      $error("program counter too narrow for depth");
   end

   mtile_mode_e       mode;
   logic              mode_ins, cfg_ok, restart;
   logic [1:0]        gnt;
   logic              sel;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_we, in_range;
   logic              ram_en, ram_we;
   logic [AW-1:0]     ram_addr, f_addr;
   logic [DATA_W-1:0] ram_q;
   logic              f_rd_en;
   logic [1:0]        rsp_valid_q;
   logic              rsp_err_q, rsp_rd_q;

   assign mode_ins = (mode == MODE_INSTR);
   assign cfg_ok   = cfg_we && !(|req_valid) && !br_valid;
   assign restart  = cfg_ok && (cfg_mode != mode);

   always_ff @(posedge clk) begin
      if (!rst_n)      mode <= MODE_DATA;
      else if (cfg_ok) mode <= mtile_mode_e'(cfg_mode);
   end

   mtile_arb i_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (!mode_ins),
      .req    (req_valid),
      .gnt    (gnt)
   );
   assign req_ready = gnt;

   assign sel      = gnt[1];
   assign cur_addr = req_addr[sel];
   assign cur_we   = req_we[sel];
   assign in_range = {1'b0, cur_addr} < DEPTH_L;

   mtile_fetch #(
      .PC_W    (PC_W),
      .AW      (AW),
      .DATA_W  (DATA_W),
      .INSTR_W (INSTR_W),
      .WPI     (WORDS_PER_INSTR),
      .PC_MAX  (PC_MAX)
   ) i_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (mode_ins),
      .restart   (restart),
      .br_valid  (br_valid),
      .br_target (br_target),
      .ins_ready (ins_ready),
      .q         (ram_q),
      .rd_en     (f_rd_en),
      .rd_addr   (f_addr),
      .ins_valid (ins_valid),
      .ins_data  (ins_data),
      .ins_err   (ins_err)
   );

   assign ram_en   = mode_ins ? f_rd_en : (|gnt && in_range);
   assign ram_we   = !mode_ins && cur_we;
   assign ram_addr = mode_ins ? f_addr : cur_addr[AW-1:0];

   mtile_ram #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) i_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (req_wdata[sel]),
      .q     (ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 2'b00;
         rsp_err_q   <= 1'b0;
         rsp_rd_q    <= 1'b0;
      end else begin
         rsp_valid_q <= gnt;
         rsp_err_q   <= !in_range;
         rsp_rd_q    <= !cur_we && in_range;
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rsp
      assign rsp_valid[p] = rsp_valid_q[p];
      assign rsp_err[p]   = rsp_valid_q[p] & rsp_err_q;
      assign rsp_rdata[p] = (rsp_valid_q[p] && rsp_rd_q) ? ram_q : '0;
   end
endmodule

// File: rtl/mem_tile_stream_chk.sv
module mem_tile_stream_chk #(
   parameter int DATA_W  = 16,
   parameter int INSTR_W = 40
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_we,
   input logic                   mode_ins,
   input logic [1:0]             req_valid,
   input logic [1:0]             req_ready,
   input logic [1:0]             rsp_valid,
   input logic [1:0]             rsp_err,
   input logic [1:0][DATA_W-1:0] rsp_rdata,
   input logic                   br_valid,
   input logic                   ins_valid,
   input logic                   ins_ready,
   input logic [INSTR_W-1:0]     ins_data,
   input logic                   ins_err
);
   assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_ready) |=> (rsp_valid == $past(req_ready)));

   assert_loser_next_p1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == 2'b11 && req_ready == 2'b01) |=> (!req_valid[1] || req_ready[1]));

   assert_loser_next_p0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == 2'b11 && req_ready == 2'b10) |=> (!req_valid[0] || req_ready[0]));

   assert_lone_p0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ins && req_valid == 2'b01) |-> req_ready == 2'b01);

   assert_lone_p1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ins && req_valid == 2'b10) |-> req_ready == 2'b10);

   assert_err_p0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err[0] |-> rsp_rdata[0] == '0);

   assert_err_p1_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err[1] |-> rsp_rdata[1] == '0);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !ins_ready && !br_valid && !cfg_we)
      |=> (ins_valid && $stable(ins_data) && $stable(ins_err)));

   assert_branch_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && mode_ins) |=> !ins_valid);

   assert_err_instr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_err) |-> ins_data == '0);

   assert_no_grant_instr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ins |-> req_ready == 2'b00);

   assert_no_stream_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ins |-> !ins_valid);
endmodule

bind mem_tile_stream mem_tile_stream_chk #(
   .DATA_W  (DATA_W),
   .INSTR_W (INSTR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .mode_ins  (mode_ins),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .br_valid  (br_valid),
   .ins_valid (ins_valid),
   .ins_ready (ins_ready),
   .ins_data  (ins_data),
   .ins_err   (ins_err)
);

// File: tb/test_mem_tile_stream.sv
module test_mem_tile_stream;
   localparam int DEPTH = 2048;
   localparam int PCMAX = DEPTH / 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0, cfg_mode = 1'b0;
   logic [1:0]        req_valid = '0, req_we = '0, req_ready;
   logic [1:0][15:0]  req_addr = '0, req_wdata = '0;
   logic [1:0]        rsp_valid, rsp_err;
   logic [1:0][15:0]  rsp_rdata;
   logic              br_valid = 1'b0;
   logic [15:0]       br_target = '0;
   logic              ins_valid, ins_ready = 1'b0, ins_err;
   logic [39:0]       ins_data;

   int checks = 0, errors = 0;
   int lastg = 1;
   logic [15:0] model [DEPTH];

   always #5 clk = ~clk;

   mem_tile_stream i_mem_tile_stream (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .br_valid(br_valid),
      .br_target(br_target), .ins_valid(ins_valid), .ins_ready(ins_ready),
      .ins_data(ins_data), .ins_err(ins_err)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [39:0] exp_instr(input int k);
      return {model[3*k+2][7:0], model[3*k+1], model[3*k]};
   endfunction

   task automatic access(input int p, input bit we, input logic [15:0] a,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output bit er);
      int waits = 0;
      @(negedge clk);
      req_valid[p] = 1'b1; req_we[p] = we; req_addr[p] = a; req_wdata[p] = wd;
      #1;
      while (!req_ready[p] && waits < 50) begin
         @(negedge clk); #1; waits++;
      end
      check(waits == 0, "R3 lone request granted at once", 64'(waits), 64'd0);
      @(negedge clk);
      req_valid[p] = 1'b0;
      check(rsp_valid[p] == 1'b1, "R1 response on granted port", 64'(rsp_valid), 64'(1 << p));
      rd = rsp_rdata[p];
      er = rsp_err[p];
      lastg = p;
   endtask

   task automatic wr(input int p, input int a, input logic [15:0] d);
      logic [15:0] rd; bit er;
      access(p, 1'b1, 16'(a), d, rd, er);
      check(er == 1'b0, "R1 in-range write no error", 64'(er), 64'd0);
      if (a < DEPTH) model[a] = d;
   endtask

   task automatic rd_check(input int p, input int a, input string req);
      logic [15:0] rd; bit er;
      access(p, 1'b0, 16'(a), 16'h0, rd, er);
      check(rd == model[a] && !er, req, {47'd0, er, rd}, {48'd0, model[a]});
   endtask

   task automatic set_mode(input bit m);
      @(negedge clk); cfg_we = 1'b1; cfg_mode = m;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic get_instr(output logic [39:0] d, output bit e);
      int n = 0;
      @(negedge clk); ins_ready = 1'b1;
      while (!ins_valid && n < 40) begin
         @(negedge clk); n++;
      end
      d = ins_data; e = ins_err;
      @(negedge clk); ins_ready = 1'b0;
   endtask

   task automatic expect_instr(input int k, input string req);
      logic [39:0] d; bit e;
      get_instr(d, e);
      check(d == exp_instr(k) && !e, req, {23'd0, e, d}, {24'd0, exp_instr(k)});
   endtask

   task automatic branch(input int t);
      @(negedge clk); br_valid = 1'b1; br_target = 16'(t);
      @(negedge clk); br_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] rd; bit er;
      logic [39:0] d; bit e;
      void'($urandom(32'h1234_5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(ins_valid == 1'b0 && rsp_valid == 2'b00, "R11 idle after reset",
            {62'd0, ins_valid, |rsp_valid}, 64'd0);
      // R1 fill program area with random words (top bytes random too: R5)
      for (int a = 0; a < 60; a++) wr(a % 2, a, 16'($urandom));
      for (int a = 3*(PCMAX-1); a < DEPTH; a++) wr(1, a, 16'($urandom));
      // R1 random mix of reads and writes
      for (int i = 0; i < 40; i++) begin
         int a = int'($urandom % 60);
         int p = int'($urandom % 2);
         if ($urandom % 3 == 0) wr(p, a, 16'($urandom));
         else rd_check(p, a, "R1 random read");
      end
      // R4 out of range
      access(0, 1'b0, 16'(DEPTH), 16'h0, rd, er);
      check(er && rd == 0, "R4 read past depth", {47'd0, er, rd}, 64'h10000);
      access(1, 1'b0, 16'hFFFF, 16'h0, rd, er);
      check(er && rd == 0, "R4 read at top address", {47'd0, er, rd}, 64'h10000);
      access(0, 1'b1, 16'(DEPTH + 2), 16'hDEAD, rd, er);
      check(er == 1'b1, "R4 write past depth flagged", 64'(er), 64'd1);
      rd_check(1, 2, "R4 write past depth leaves word 2 intact");
      // R2 collisions
      for (int r = 0; r < 3; r++) begin
         int w, l;
         w = (lastg == 1) ? 0 : 1;
         l = 1 - w;
         @(negedge clk);
         req_valid = 2'b11; req_we = 2'b00;
         req_addr[0] = 16'(r); req_addr[1] = 16'(r + 10);
         #1;
         check(req_ready == 2'(1 << w), "R2 winner of collision", 64'(req_ready), 64'(1 << w));
         @(negedge clk);
         req_valid[w] = 1'b0;
         check(rsp_valid[w] && rsp_rdata[w] == model[w == 0 ? r : r + 10],
               "R2 winner data", 64'(rsp_rdata[w]), 64'(model[w == 0 ? r : r + 10]));
         #1;
         check(req_ready[l] == 1'b1, "R2 loser served next cycle", 64'(req_ready), 64'(1 << l));
         @(negedge clk);
         req_valid[l] = 1'b0;
         check(rsp_valid[l] && rsp_rdata[l] == model[l == 0 ? r : r + 10],
               "R2 loser data", 64'(rsp_rdata[l]), 64'(model[l == 0 ? r : r + 10]));
         lastg = l;
      end
      // R10 data mode: no stream even with branch
      branch(3);
      repeat (6) @(negedge clk);
      check(ins_valid == 1'b0, "R10 no instruction in data mode", 64'(ins_valid), 64'd0);
      // enter instruction mode
      set_mode(1'b1);
      // R9 ignored cfg write while a request is pending; R10 no grant
      @(negedge clk);
      req_valid[0] = 1'b1; req_we[0] = 1'b0; req_addr[0] = 16'h0;
      cfg_we = 1'b1; cfg_mode = 1'b0;
      #1;
      check(req_ready == 2'b00, "R10 no grant in instruction mode", 64'(req_ready), 64'd0);
      @(negedge clk);
      cfg_we = 1'b0; req_valid[0] = 1'b0;
      // R5 R6 in-order stream from counter 0 (mode stayed: R9)
      expect_instr(0, "R9 R5 first instruction after ignored cfg");
      expect_instr(1, "R5 R6 instruction 1");
      expect_instr(2, "R5 R6 instruction 2");
      // R6 stall
      repeat (8) @(negedge clk);
      d = ins_data;
      check(ins_valid == 1'b1 && d == exp_instr(3), "R6 prefetched instruction 3",
            64'(d), 64'(exp_instr(3)));
      repeat (5) @(negedge clk);
      check(ins_valid == 1'b1 && ins_data == d, "R6 held while not ready",
            64'(ins_data), 64'(d));
      expect_instr(3, "R6 stalled instruction delivered");
      expect_instr(4, "R6 instruction 4");
      // R7 branch discards prefetch
      repeat (8) @(negedge clk);
      check(ins_valid == 1'b1, "R7 instruction 5 prefetched", 64'(ins_valid), 64'd1);
      branch(12);
      check(ins_valid == 1'b0, "R7 prefetch dropped", 64'(ins_valid), 64'd0);
      expect_instr(12, "R7 branch target delivered");
      expect_instr(13, "R7 continues after target");
      // R8 end of program space
      branch(PCMAX - 1);
      expect_instr(PCMAX - 1, "R8 last legal instruction");
      get_instr(d, e);
      check(e && d == 0, "R8 counter at limit", {23'd0, e, d}, 64'h100_0000_0000);
      get_instr(d, e);
      check(e && d == 0, "R8 counter stays at limit", {23'd0, e, d}, 64'h100_0000_0000);
      branch(16'h8000);
      get_instr(d, e);
      check(e && d == 0, "R8 far branch target", {23'd0, e, d}, 64'h100_0000_0000);
      // R9 mode change clears counter
      set_mode(1'b0);
      repeat (4) @(negedge clk);
      check(ins_valid == 1'b0, "R10 stream stops in data mode", 64'(ins_valid), 64'd0);
      rd_check(0, 7, "R1 data access after leaving instruction mode");
      set_mode(1'b1);
      expect_instr(0, "R9 counter cleared by mode change");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule